// File: doc/BRIEF.md
# Binary-Weighted Bit-Plane PWM Sequencer

This block drives a small array of two-state light switches from 8-bit gray-level pixel words. The switches are bistable: each one is either fully on (bright) or fully off (dark). Intermediate brightness comes from binary-weighted pulse-width modulation across one field. A field-start strobe samples every pixel word into a field buffer. The sequencer then shows the eight bit planes of those words one after another, most significant first. The slot for bit k lasts 2^k base ticks, so a whole field covers 255 base ticks and a pixel's total on-time equals its gray value.

Each plane is written into a per-pixel staging latch while the previous plane is still on display. A single global update strobe then copies every latch to its output together, so all pixels change state on the same edge. Each pixel drives a true and an inverted address output. After the least significant slot ends, all outputs return to off and the block waits for the next field start. A field start that arrives in mid-field abandons the running field and restarts from the most significant plane with freshly sampled words.

Top module: `pwm_plane_seq`

## Requirements
- R1: During and after reset, and before any field start, every `sw_on_o` bit is 0, every `sw_on_n_o` bit is 1, and `load_o` and `update_o` are low.
- R2: Pixel words are captured only on the clock edge where `field_start_i` is high. A change on `pix_words_i` later in the field has no effect on that field's outputs.
- R3: In the cycle after the field-start edge, `load_o` is high. In the cycle after that, `update_o` is high. At the end of the update cycle, `sw_on_o[p]` takes bit 7 of pixel p's sampled word.
- R4: Planes are shown from bit 7 down to bit 0. The outputs hold bit k for exactly TICK_DIV·2^k clock cycles, where one base tick is TICK_DIV clocks.
- R5: Over one complete field, each pixel's `sw_on_o` bit is high for exactly (pixel value)·TICK_DIV cycles.
- R6: Each complete field produces exactly 8 `update_o` pulses and exactly 8 `load_o` pulses.
- R7: Loading a plane into the staging latches does not change the outputs. Outputs change only on the edge that ends an `update_o` cycle, or at the end of the field.
- R8: `sw_on_n_o` is always the bitwise complement of `sw_on_o`.
- R9: When the bit-0 slot ends, all outputs go off without an update pulse. No further strobes occur until the next field start.
- R10: A field start during a running field abandons that field. The R3 timing then restarts with the newly sampled words, and the new field completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| field_start_i | input | 1 | Field-start strobe; samples the pixel words |
| pix_words_i | input | NUM_PIX*GRAY_W | Gray level of each pixel; pixel p occupies bits [p*GRAY_W +: GRAY_W] |
| sw_on_o | output | NUM_PIX | Switch state per pixel, 1 = on |
| sw_on_n_o | output | NUM_PIX | Inverted switch state per pixel |
| load_o | output | 1 | High in a cycle whose closing edge writes a plane into the staging latches |
| update_o | output | 1 | High in a cycle whose closing edge copies the latches to the outputs |

## Verification
The uniform extremes, all 0 and all 255, show whether any slot is missing or stretched, because the on-time must be either nothing or the full field. Mixed words such as 0/1/128/255 and the alternating 0xAA/0x55 pair separate the MSB and LSB slot lengths and expose any swap in plane order. Seeded random words cover the remaining weight combinations. One field has its inputs scrambled right after sampling, to show that the field buffer isolates the display from input changes. Another field is cut short by a second start, to show the restart behaviour.

// File: rtl/pwm_seq_pkg.sv
package pwm_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_COMMIT,
    ST_RUN
  } seq_state_e;
endpackage

// File: rtl/plane_field_buf.sv
module plane_field_buf #(
  parameter int NUM_PIX = 4,
  parameter int GRAY_W  = 8,
  localparam int SEL_W  = $clog2(GRAY_W)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      capture_i,
  input  logic [NUM_PIX*GRAY_W-1:0] words_i,
  input  logic [SEL_W-1:0]          plane_sel_i,
  output logic [NUM_PIX-1:0]        plane_o
);
  logic [NUM_PIX-1:0][GRAY_W-1:0] words_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        words_q <= '0;
    else if (capture_i) words_q <= words_i;
  end

  for (genvar p = 0; p < NUM_PIX; p++) begin : g_sel
    assign plane_o[p] = words_q[p][plane_sel_i];
  end

  // the field buffer only changes on a field start
  assert_buf_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> $stable(words_q));
endmodule

// File: rtl/slot_ctrl.sv
module slot_ctrl
  import pwm_seq_pkg::*;
#(
  parameter int GRAY_W   = 8,
  parameter int TICK_DIV = 2,
  localparam int SEL_W   = $clog2(GRAY_W),
  localparam int CNT_W   = $clog2(TICK_DIV) + GRAY_W,
  localparam int UPD_W   = SEL_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             load_o,
  output logic             update_o,
  output logic             blank_o,
  output logic [SEL_W-1:0] plane_sel_o
);
  seq_state_e       state_q;
  logic [SEL_W-1:0] slot_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] slot_len;
  logic [CNT_W-1:0] last;
  logic             in_run;
  logic             at_end;

  assign slot_len = CNT_W'(TICK_DIV) << slot_q;
  assign last     = slot_len - CNT_W'(1);
  assign in_run   = (state_q == ST_RUN);
  assign at_end   = in_run && (cnt_q == last);

  assign load_o      = (state_q == ST_LOAD) || (in_run && cnt_q == '0 && slot_q != '0);
  assign update_o    = (state_q == ST_COMMIT) || (at_end && slot_q != '0);
  assign blank_o     = at_end && (slot_q == '0);
  assign plane_sel_o = (state_q == ST_LOAD) ? SEL_W'(GRAY_W - 1) : slot_q - SEL_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      cnt_q   <= '0;
    end else if (start_i) begin
      state_q <= ST_LOAD;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_LOAD:   state_q <= ST_COMMIT;
        ST_COMMIT: begin
          state_q <= ST_RUN;
          slot_q  <= SEL_W'(GRAY_W - 1);
          cnt_q   <= '0;
        end
        ST_RUN: begin
          if (cnt_q == last) begin
            cnt_q <= '0;
            if (slot_q == '0) state_q <= ST_IDLE;
            else              slot_q  <= slot_q - SEL_W'(1);
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // updates seen since the last field start
  logic [UPD_W-1:0] upd_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       upd_seen_q <= '0;
    else if (start_i)  upd_seen_q <= '0;
    else if (update_o) upd_seen_q <= upd_seen_q + UPD_W'(1);
  end

  assert_upd_count_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |-> (upd_seen_q < UPD_W'(GRAY_W)));
  assert_strobe_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_o && update_o));
  assert_slot_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_run && update_o && !start_i) |=> (slot_q == SEL_W'($past(slot_q) - SEL_W'(1))));
  assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_run |-> (cnt_q <= last));
  assert_commit_follows_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOAD && !start_i) |=> update_o);
endmodule

// File: rtl/pixel_cell.sv
module pixel_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic update_i,
  input  logic blank_i,
  input  logic bit_i,
  output logic on_o,
  output logic on_n_o
);
  logic latch_q;
  logic on_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     latch_q <= 1'b0;
    else if (load_i) latch_q <= bit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        on_q <= 1'b0;
    else if (update_i)  on_q <= latch_q;
    else if (blank_i)   on_q <= 1'b0;
  end

  assign on_o   = on_q;
  assign on_n_o = ~on_q;

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!update_i && !blank_i) |=> $stable(on_q));
  assert_commit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_i |=> (on_q == $past(latch_q)));
  assert_blank_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_i && !update_i) |=> !on_q);
endmodule

// File: rtl/pwm_plane_seq.sv
module pwm_plane_seq #(
  parameter int NUM_PIX  = 4,
  parameter int GRAY_W   = 8,
  parameter int TICK_DIV = 2,
  localparam int SEL_W   = $clog2(GRAY_W)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      field_start_i,
  input  logic [NUM_PIX*GRAY_W-1:0] pix_words_i,
  output logic [NUM_PIX-1:0]        sw_on_o,
  output logic [NUM_PIX-1:0]        sw_on_n_o,
  output logic                      load_o,
  output logic                      update_o
);
  logic             load;
  logic             update;
  logic             blank;
  logic [SEL_W-1:0] plane_sel;
  logic [NUM_PIX-1:0] plane;

  plane_field_buf #(.NUM_PIX(NUM_PIX), .GRAY_W(GRAY_W)) u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .capture_i   (field_start_i),
    .words_i     (pix_words_i),
    .plane_sel_i (plane_sel),
    .plane_o     (plane)
  );

  slot_ctrl #(.GRAY_W(GRAY_W), .TICK_DIV(TICK_DIV)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (field_start_i),
    .load_o      (load),
    .update_o    (update),
    .blank_o     (blank),
    .plane_sel_o (plane_sel)
  );

  for (genvar p = 0; p < NUM_PIX; p++) begin : g_pix
    pixel_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (load),
      .update_i (update),
      .blank_i  (blank),
      .bit_i    (plane[p]),
      .on_o     (sw_on_o[p]),
      .on_n_o   (sw_on_n_o[p])
    );
  end

  assign load_o   = load;
  assign update_o = update;

  assert_compl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_on_n_o == ~sw_on_o);
  assert_start_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    field_start_i |=> load_o);
endmodule

// File: tb/tb_pwm_plane_seq.sv
`timescale 1ns/1ps
module tb_pwm_plane_seq;
  localparam int NP = 4;
  localparam int GW = 8;
  localparam int TD = 2;
  localparam int FIELD_CYC = 255 * TD;
  localparam real CLK_P = 8.0;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [NP*GW-1:0] pix = '0;
  logic [NP-1:0]    sw_on;
  logic [NP-1:0]    sw_on_n;
  logic             load;
  logic             upd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  pwm_plane_seq #(.NUM_PIX(NP), .GRAY_W(GW), .TICK_DIV(TD)) dut (
    .clk_i(clk), .rst_ni(rst_n), .field_start_i(start), .pix_words_i(pix),
    .sw_on_o(sw_on), .sw_on_n_o(sw_on_n), .load_o(load), .update_o(upd)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected switch state t cycles into the displayed field
  function automatic bit exp_bit(input logic [GW-1:0] w, input int t);
    int rem = t;
    for (int k = GW - 1; k >= 0; k--) begin
      if (rem < (TD << k)) return w[k];
      rem -= (TD << k);
    end
    return 1'b0;
  endfunction

  task automatic run_field(input logic [NP*GW-1:0] w, input bit mid_change, input bit from_idle);
    int on_time [NP];
    int loads, upds, mism, unexp, compl, late;
    logic [NP-1:0] prev;
    logic [NP-1:0] exp7;
    bit prev_upd;
    @(negedge clk);
    pix = w;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (mid_change) pix = ~w ^ (NP*GW)'($urandom);
    check(load && !upd, "R3", "load one cycle after start", {load, upd}, 2);
    if (from_idle) check(sw_on == '0, "R9", "off before field", sw_on, 0);
    @(negedge clk);
    check(upd && !load, "R3", "update second cycle", {upd, load}, 2);
    if (from_idle) check(sw_on == '0, "R7", "latch load not visible", sw_on, 0);
    loads = 1; upds = 1; mism = 0; unexp = 0; compl = 0; late = 0;
    for (int p = 0; p < NP; p++) on_time[p] = 0;
    prev = sw_on;
    prev_upd = 1'b1;
    for (int t = 0; t < FIELD_CYC + 4; t++) begin
      @(negedge clk);
      if (t == 0) begin
        for (int p = 0; p < NP; p++) exp7[p] = w[p*GW + GW - 1];
        check(sw_on == exp7, "R3", "MSB plane after update", sw_on, exp7);
      end
      if (sw_on_n != ~sw_on) compl++;
      if (sw_on != prev && !prev_upd && t != FIELD_CYC) unexp++;
      if (t >= FIELD_CYC && (load || upd)) late++;
      if (t < FIELD_CYC) begin
        if (load) loads++;
        if (upd) upds++;
      end
      for (int p = 0; p < NP; p++) begin
        bit e = (t < FIELD_CYC) ? exp_bit(w[p*GW +: GW], t) : 1'b0;
        if (sw_on[p]) on_time[p]++;
        if (sw_on[p] != e) mism++;
      end
      prev = sw_on;
      prev_upd = upd;
    end
    check(mism == 0, mid_change ? "R2" : "R4", "plane order/slot length mismatches", mism, 0);
    for (int p = 0; p < NP; p++)
      check(on_time[p] == int'(w[p*GW +: GW]) * TD, "R5", $sformatf("on-time pixel %0d", p),
            on_time[p], int'(w[p*GW +: GW]) * TD);
    check(upds == GW, "R6", "update pulses per field", upds, GW);
    check(loads == GW, "R6", "load pulses per field", loads, GW);
    check(unexp == 0, "R7", "output changes without update", unexp, 0);
    check(compl == 0, "R8", "complement violations", compl, 0);
    check(late == 0 && sw_on == '0, "R9", "idle and off after field", late + int'(sw_on), 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check(sw_on == '0 && sw_on_n == '1 && !load && !upd, "R1", "outputs in reset",
          {sw_on, sw_on_n, load, upd}, {NP'(0), {NP{1'b1}}, 2'b00});
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(sw_on == '0 && sw_on_n == '1 && !load && !upd, "R1", "idle after reset",
            {sw_on, sw_on_n, load, upd}, {NP'(0), {NP{1'b1}}, 2'b00});
    end
    // directed corner words
    run_field({8'd0, 8'd0, 8'd0, 8'd0}, 0, 1);
    run_field({8'd255, 8'd255, 8'd255, 8'd255}, 0, 1);
    run_field({8'd255, 8'd128, 8'd1, 8'd0}, 0, 1);
    run_field({8'h55, 8'hAA, 8'h55, 8'hAA}, 0, 1);
    // R2: inputs scrambled right after sampling
    run_field({8'd200, 8'd17, 8'd99, 8'd64}, 1, 1);
    // R10: abort a running field mid-MSB slot, then restart
    @(negedge clk);
    pix = {8'd255, 8'd255, 8'd255, 8'd255};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    check(sw_on == '1, "R10", "first field running before abort", sw_on, {NP{1'b1}});
    run_field({8'd3, 8'd140, 8'd0, 8'd77}, 0, 0);
    // seeded random fields
    for (int i = 0; i < 6; i++) run_field((NP*GW)'($urandom), (i == 2), 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule